// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the software-visible register bank of a UART peripheral on a 32-bit memory-mapped bus that uses word accesses only. It keeps the interrupt state, interrupt enable and interrupt test registers, the control register, the FIFO control register and the receive data byte. It assembles the read-only status and FIFO status words, and it drives four level-sensitive interrupt lines. The transmit FIFO and the receiver around it send single-cycle event pulses and level information into the bank. Writes to the transmit data slot come out as a one-cycle push towards the transmit FIFO.

A bus access is a single cycle on which `bus_valid` is high, with `bus_write` choosing the direction. Read data is registered and is returned one cycle later. Interrupt state bits are sticky: hardware events set them, a write of ones to the state slot clears them, and a write to the test slot forces them on. A read of the receive data slot has side effects on the receive status flags and on the receive level.

Top module: `uart_csr_top`

## Requirements
- R1: After reset the interrupt state, interrupt enable, control and FIFO control registers, the receive byte and the receive level are all zero, all four interrupt outputs, `rx_ready` and `tx_push` are low, and the status word at offset 0x14 reads 0x3C.
- R2: A pulse on an event input sets its interrupt state bit (bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit empty, bit 3 receive overflow), and the bit stays set until software clears it.
- R3: Each interrupt output is the AND of its state bit and the enable bit of the same position (enable register at offset 0x04). The output changes on the same clock edge as the register that caused the change.
- R4: A write to offset 0x00 clears every state bit written as 1 and leaves the bits written as 0 unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: A write to offset 0x08 ORs the low four written bits into the interrupt state. Reads of offset 0x08 and of offset 0x1C return zero.
- R6: A byte on `rx_byte_valid` is taken only when receive enable (control bit 1, offset 0x10) is set and receive full is clear; this condition is shown on `rx_ready`. A taken byte is stored, sets receive full (status bit 1), clears receive idle (bit 4) and receive empty (bit 5), and raises the receive level by one. A byte that is not taken changes nothing.
- R7: A read of offset 0x18 returns the stored byte in bits 7:0. When receive is enabled and the level is nonzero, that read lowers the level by one and clears receive full, and when the level reaches zero it sets receive idle and receive empty. With receive disabled the read has no side effect.
- R8: Writes to offsets 0x14, 0x18 and 0x24 change no register.
- R9: An access to an unmapped offset (0x0C, any offset from 0x28 up, or an address with nonzero bits 1:0) reads as zero, and a write there changes no register.
- R10: A write to offset 0x1C gives a one-cycle pulse on `tx_push` on the following cycle, with written bits 7:0 on `tx_push_data`.
- R11: Status bit 0 and bit 2 follow `tx_fifo_full` and `tx_fifo_empty` with one cycle of delay, and status bit 3 reads 1. The FIFO status word at 0x24 holds the transmit level in bits 4:0 and the receive level in bits 20:16.
- R12: Read data for a request accepted on a clock edge appears on `bus_rdata` after that edge and holds until the next read. The control (0x10) and FIFO control (0x20) registers read back what was written and drive `ctrl_value` and `fifo_ctrl_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_tx_watermark | input | 1 | Transmit watermark event pulse |
| ev_rx_watermark | input | 1 | Receive watermark event pulse |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| rx_byte_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | A byte offered now would be taken |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_fifo_level | input | LVL_W | Transmit FIFO fill level |
| tx_push | output | 1 | Transmit byte push pulse |
| tx_push_data | output | 8 | Byte to push |
| ctrl_value | output | 32 | Control register contents |
| fifo_ctrl_value | output | 32 | FIFO control register contents |
| irq_tx_watermark | output | 1 | Transmit watermark interrupt |
| irq_rx_watermark | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit empty interrupt |
| irq_rx_overflow | output | 1 | Receive overflow interrupt |

## Verification
Every register effect of a write, event or received byte lands on the edge that captures it, so the interrupt lines, `rx_ready` and `tx_push` are checked at the falling edge that follows that capture edge, and register contents are checked by a later read. Read data is due one edge after the request; the driver queues the expected word when it issues a read, and the monitor waits for the capture edge and then the next falling edge before comparing. The status bits that mirror the transmit FIFO lag their inputs by one cycle, so the bench changes those inputs and idles a full cycle before reading. Same-cycle collisions, such as an event meeting a clearing write, are driven in a single cycle so that the priority is what gets checked.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_IRQ   = 4;
  localparam int unsigned NUM_SLOTS = 10;

  // Word slots of the register map (byte offset = slot * 4)
  localparam int unsigned SLOT_ISTATE = 0;
  localparam int unsigned SLOT_IEN    = 1;
  localparam int unsigned SLOT_ITEST  = 2;
  localparam int unsigned SLOT_CTRL   = 4;
  localparam int unsigned SLOT_STATUS = 5;
  localparam int unsigned SLOT_RDATA  = 6;
  localparam int unsigned SLOT_WDATA  = 7;
  localparam int unsigned SLOT_FCTRL  = 8;
  localparam int unsigned SLOT_FSTAT  = 9;

  // Slot 3 is a hole in the map
  localparam logic [NUM_SLOTS-1:0] SLOT_MAPPED = 10'b11_1111_0111;

  // Interrupt bit positions
  localparam int unsigned IRQ_TXWM  = 0;
  localparam int unsigned IRQ_RXWM  = 1;
  localparam int unsigned IRQ_TXEMP = 2;
  localparam int unsigned IRQ_RXOVF = 3;

  localparam int unsigned CTRL_RX_EN_BIT = 1;
  localparam int unsigned FSTAT_RX_POS   = 16;

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 bus_valid,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_SLOTS-1:0] sel_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (SLOT_MAPPED[g]) begin : g_map
      assign sel_o[g] = bus_valid && aligned &&
                        (bus_addr[ADDR_W-1:2] == IDX_W'(g));
    end else begin : g_hole
      assign sel_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/uart_intr_bank.sv
module uart_intr_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wdata,
  input  logic         clr_we,
  input  logic         set_we,
  input  logic         en_we,
  input  logic [N-1:0] ev,
  output logic [N-1:0] state_o,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st_q, en_q, irq_q, st_nx, en_nx;

    // events and test writes win over a clearing write
    assign st_nx = (st_q & ~(clr_we & wdata[i])) | (set_we & wdata[i]) | ev[i];
    assign en_nx = en_we ? wdata[i] : en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q  <= 1'b0;
        en_q  <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        st_q  <= st_nx;
        en_q  <= en_nx;
        irq_q <= st_nx & en_nx;
      end
    end

    assign state_o[i]  = st_q;
    assign enable_o[i] = en_q;
    assign irq_o[i]    = irq_q;
  end
endmodule

// File: rtl/uart_rx_tracker.sv
module uart_rx_tracker #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  input  logic             rd_pop,
  output logic             rx_ready,
  output logic             rx_full,
  output logic             rx_idle,
  output logic             rx_empty,
  output logic [LVL_W-1:0] level,
  output logic [7:0]       byte_q
);
  logic             full_q, idle_q, empty_q;
  logic [LVL_W-1:0] lvl_q, lvl_nx;
  logic             accept, pop;

  assign accept = byte_valid & rx_en & ~full_q;
  assign pop    = rd_pop & rx_en & (lvl_q != '0);
  assign lvl_nx = lvl_q + LVL_W'(accept) - LVL_W'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      idle_q  <= 1'b1;
      empty_q <= 1'b1;
      lvl_q   <= '0;
      byte_q  <= '0;
    end else begin
      lvl_q <= lvl_nx;
      if (accept) begin
        byte_q  <= byte_in;
        full_q  <= 1'b1;
        idle_q  <= 1'b0;
        empty_q <= 1'b0;
      end else if (pop) begin
        full_q <= 1'b0;
        if (lvl_nx == '0) begin
          idle_q  <= 1'b1;
          empty_q <= 1'b1;
        end
      end
    end
  end

  assign rx_ready = rx_en & ~full_q;
  assign rx_full  = full_q;
  assign rx_idle  = idle_q;
  assign rx_empty = empty_q;
  assign level    = lvl_q;
endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_tx_watermark,
  input  logic              ev_rx_watermark,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_overflow,
  input  logic              rx_byte_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  input  logic              tx_fifo_full,
  input  logic              tx_fifo_empty,
  input  logic [LVL_W-1:0]  tx_fifo_level,
  output logic              tx_push,
  output logic [7:0]        tx_push_data,
  output logic [31:0]       ctrl_value,
  output logic [31:0]       fifo_ctrl_value,
  output logic              irq_tx_watermark,
  output logic              irq_rx_watermark,
  output logic              irq_tx_empty,
  output logic              irq_rx_overflow
);
  logic [NUM_SLOTS-1:0] sel;
  logic                 wr, rd;
  logic [NUM_IRQ-1:0]   ev_vec, intr_state, intr_enable, irq_vec;
  logic                 rx_full, rx_idle, rx_empty;
  logic [LVL_W-1:0]     rx_level;
  logic [7:0]           rx_data;

  logic [31:0] ctrl_q, fctrl_q, rdata_q;
  logic        tx_full_q, tx_empty_q, push_q;
  logic [7:0]  push_data_q;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  uart_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .sel_o     (sel)
  );

  assign ev_vec[IRQ_TXWM]  = ev_tx_watermark;
  assign ev_vec[IRQ_RXWM]  = ev_rx_watermark;
  assign ev_vec[IRQ_TXEMP] = ev_tx_empty;
  assign ev_vec[IRQ_RXOVF] = ev_rx_overflow;

  uart_intr_bank #(.N(NUM_IRQ)) i_intr (
    .clk      (clk),
    .rst      (rst),
    .wdata    (bus_wdata[NUM_IRQ-1:0]),
    .clr_we   (wr & sel[SLOT_ISTATE]),
    .set_we   (wr & sel[SLOT_ITEST]),
    .en_we    (wr & sel[SLOT_IEN]),
    .ev       (ev_vec),
    .state_o  (intr_state),
    .enable_o (intr_enable),
    .irq_o    (irq_vec)
  );

  assign irq_tx_watermark = irq_vec[IRQ_TXWM];
  assign irq_rx_watermark = irq_vec[IRQ_RXWM];
  assign irq_tx_empty     = irq_vec[IRQ_TXEMP];
  assign irq_rx_overflow  = irq_vec[IRQ_RXOVF];

  uart_rx_tracker #(.LVL_W(LVL_W)) i_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (ctrl_q[CTRL_RX_EN_BIT]),
    .byte_valid (rx_byte_valid),
    .byte_in    (rx_byte),
    .rd_pop     (rd & sel[SLOT_RDATA]),
    .rx_ready   (rx_ready),
    .rx_full    (rx_full),
    .rx_idle    (rx_idle),
    .rx_empty   (rx_empty),
    .level      (rx_level),
    .byte_q     (rx_data)
  );

  // Read words of every slot; unmapped and write-only slots read as zero
  logic [31:0] rd_val [NUM_SLOTS];
  logic [31:0] status_w, fstat_w, rd_mux;

  assign status_w = {26'd0, rx_empty, rx_idle, 1'b1, tx_empty_q, rx_full, tx_full_q};

  always_comb begin
    fstat_w = '0;
    fstat_w[LVL_W-1:0]             = tx_fifo_level;
    fstat_w[FSTAT_RX_POS +: LVL_W] = rx_level;
  end

  assign rd_val[SLOT_ISTATE] = {{(DATA_W-NUM_IRQ){1'b0}}, intr_state};
  assign rd_val[SLOT_IEN]    = {{(DATA_W-NUM_IRQ){1'b0}}, intr_enable};
  assign rd_val[SLOT_ITEST]  = '0;
  assign rd_val[3]           = '0;
  assign rd_val[SLOT_CTRL]   = ctrl_q;
  assign rd_val[SLOT_STATUS] = status_w;
  assign rd_val[SLOT_RDATA]  = {24'd0, rx_data};
  assign rd_val[SLOT_WDATA]  = '0;
  assign rd_val[SLOT_FCTRL]  = fctrl_q;
  assign rd_val[SLOT_FSTAT]  = fstat_w;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel[i]) rd_mux = rd_mux | rd_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      fctrl_q     <= '0;
      rdata_q     <= '0;
      tx_full_q   <= 1'b0;
      tx_empty_q  <= 1'b1;
      push_q      <= 1'b0;
      push_data_q <= '0;
    end else begin
      tx_full_q  <= tx_fifo_full;
      tx_empty_q <= tx_fifo_empty;
      push_q     <= wr & sel[SLOT_WDATA];
      if (wr & sel[SLOT_WDATA]) push_data_q <= bus_wdata[7:0];
      if (wr & sel[SLOT_CTRL])  ctrl_q      <= bus_wdata;
      if (wr & sel[SLOT_FCTRL]) fctrl_q     <= bus_wdata;
      if (rd)                   rdata_q     <= rd_mux;
    end
  end

  assign bus_rdata       = rdata_q;
  assign tx_push         = push_q;
  assign tx_push_data    = push_data_q;
  assign ctrl_value      = ctrl_q;
  assign fifo_ctrl_value = fctrl_q;
endmodule

// File: rtl/uart_csr_checker.sv
module uart_csr_checker #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LVL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        ev_vec,
  input logic [3:0]        intr_state,
  input logic [3:0]        intr_enable,
  input logic [3:0]        irq_vec,
  input logic              rx_byte_valid,
  input logic              rx_ready,
  input logic              rx_full,
  input logic [LVL_W-1:0]  rx_level,
  input logic              tx_push
);
  logic wr_state, rd_data, wr_push, wr_unmapped;

  assign wr_state = bus_valid && bus_write && (bus_addr == ADDR_W'(0));
  assign rd_data  = bus_valid && !bus_write && (bus_addr == ADDR_W'(24));
  assign wr_push  = bus_valid && bus_write && (bus_addr == ADDR_W'(28));
  assign wr_unmapped = bus_valid && bus_write &&
                       ((bus_addr[1:0] != 2'b00) || (bus_addr == ADDR_W'(12)) ||
                        (bus_addr >= ADDR_W'(40)));

  // R2: an event leaves its state bit set on the next cycle
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_vec != 4'd0) |=> ((intr_state & $past(ev_vec)) == $past(ev_vec)));

  // R3: interrupt lines follow state AND enable
  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
    irq_vec == (intr_state & intr_enable));

  // R4: without a clearing write no state bit drops
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_state |=> ((intr_state & $past(intr_state)) == $past(intr_state)));

  // R6: a refused byte does not move the receive level
  assert_rx_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_byte_valid && !rx_ready && !rd_data) |=> $stable(rx_level));

  // R7: receive full implies a nonzero level
  assert_full_level_R7: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> (rx_level != '0));

  // R9: a write to an unmapped offset leaves interrupt registers alone
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_unmapped && ev_vec == 4'd0) |=> ($stable(intr_state) && $stable(intr_enable)));

  // R10: a push only follows a transmit data write
  assert_push_src_R10: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(wr_push));
endmodule

bind uart_csr_top uart_csr_checker #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) i_checker (
  .clk           (clk),
  .rst           (rst),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_addr      (bus_addr),
  .ev_vec        (ev_vec),
  .intr_state    (intr_state),
  .intr_enable   (intr_enable),
  .irq_vec       (irq_vec),
  .rx_byte_valid (rx_byte_valid),
  .rx_ready      (rx_ready),
  .rx_full       (rx_full),
  .rx_level      (rx_level),
  .tx_push       (tx_push)
);

// File: tb/test_uart_csr_top.sv
module test_uart_csr_top;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned LVL_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_tx_watermark = 1'b0, ev_rx_watermark = 1'b0;
  logic ev_tx_empty = 1'b0, ev_rx_overflow = 1'b0;
  logic rx_byte_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_ready;
  logic tx_fifo_full = 1'b0, tx_fifo_empty = 1'b1;
  logic [LVL_W-1:0] tx_fifo_level = '0;
  logic tx_push;
  logic [7:0] tx_push_data;
  logic [31:0] ctrl_value, fifo_ctrl_value;
  logic irq_tx_watermark, irq_rx_watermark, irq_tx_empty, irq_rx_overflow;

  always #5 clk = ~clk;

  uart_csr_top #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) i_uart_csr_top (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_watermark(ev_tx_watermark), .ev_rx_watermark(ev_rx_watermark),
    .ev_tx_empty(ev_tx_empty), .ev_rx_overflow(ev_rx_overflow),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_fifo_full(tx_fifo_full), .tx_fifo_empty(tx_fifo_empty),
    .tx_fifo_level(tx_fifo_level), .tx_push(tx_push), .tx_push_data(tx_push_data),
    .ctrl_value(ctrl_value), .fifo_ctrl_value(fifo_ctrl_value),
    .irq_tx_watermark(irq_tx_watermark), .irq_rx_watermark(irq_rx_watermark),
    .irq_tx_empty(irq_tx_empty), .irq_rx_overflow(irq_rx_overflow)
  );

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver tasks: entered and left at a falling edge
  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
    exp_t it;
    it.v = e; it.tag = tag;
    exp_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rx_send(logic [7:0] b);
    rx_byte_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_byte_valid = 1'b0;
  endtask

  // Monitor: read data is due after the capture edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_valid && !bus_write && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("R12 unexpected read data", bus_rdata, 32'hDEAD);
        else begin
          exp_t it;
          it = exp_q.pop_front();
          chk(it.tag, bus_rdata, it.v);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq lines", {irq_rx_overflow, irq_tx_empty, irq_rx_watermark, irq_tx_watermark}, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 tx_push", tx_push, 0);
    bus_rd(10'h00, 32'h0, "R1 intr state");
    bus_rd(10'h04, 32'h0, "R1 intr enable");
    bus_rd(10'h10, 32'h0, "R1 control");
    bus_rd(10'h14, 32'h3C, "R1 status");
    bus_rd(10'h18, 32'h0, "R1 rx byte");
    bus_rd(10'h20, 32'h0, "R1 fifo control");
    bus_rd(10'h24, 32'h0, "R1 fifo status");

    // R2 / R3 events and gating
    ev_rx_overflow = 1'b1; @(negedge clk); ev_rx_overflow = 1'b0;
    bus_rd(10'h00, 32'h8, "R2 overflow sticky");
    chk("R3 masked overflow", irq_rx_overflow, 0);
    bus_wr(10'h04, 32'hF);
    chk("R3 overflow irq after enable", irq_rx_overflow, 1);
    chk("R3 watermark irq idle", irq_tx_watermark, 0);
    ev_tx_watermark = 1'b1; @(negedge clk); ev_tx_watermark = 1'b0;
    chk("R3 tx watermark irq", irq_tx_watermark, 1);
    bus_rd(10'h00, 32'h9, "R2 two bits set");

    // R4 write-one-to-clear
    bus_wr(10'h00, 32'h8);
    chk("R4 overflow irq cleared", irq_rx_overflow, 0);
    bus_rd(10'h00, 32'h1, "R4 clear one bit");
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'h00; bus_wdata = 32'h1;
    ev_tx_watermark = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ev_tx_watermark = 1'b0;
    bus_rd(10'h00, 32'h1, "R4 event beats clear");
    bus_wr(10'h00, 32'hF);
    bus_rd(10'h00, 32'h0, "R4 clear all");

    // R5 test register
    bus_wr(10'h08, 32'hFFFF_FFF6);
    chk("R5 rx watermark irq", irq_rx_watermark, 1);
    chk("R5 tx empty irq", irq_tx_empty, 1);
    bus_rd(10'h00, 32'h6, "R5 test OR");
    bus_rd(10'h08, 32'h0, "R5 test reads zero");
    bus_rd(10'h1C, 32'h0, "R5 tx data reads zero");
    bus_wr(10'h04, 32'h0);
    chk("R3 irq off by enable", irq_tx_empty, 0);
    bus_wr(10'h00, 32'hF);

    // R6 receive acceptance
    tx_fifo_level = 5'd3;
    chk("R6 not ready when disabled", rx_ready, 0);
    rx_send(8'hA5);
    bus_rd(10'h14, 32'h3C, "R6 disabled byte ignored");
    bus_wr(10'h10, 32'h2);
    chk("R6 ready", rx_ready, 1);
    chk("R12 ctrl_value", ctrl_value, 32'h2);
    bus_rd(10'h10, 32'h2, "R12 control readback");
    rx_send(8'h5A);
    chk("R6 not ready when full", rx_ready, 0);
    bus_rd(10'h14, 32'h0E, "R6 status after byte");
    rx_send(8'h33);
    bus_rd(10'h24, 32'h0001_0003, "R11 fifo status levels");

    // R7 read side effects
    bus_rd(10'h18, 32'h5A, "R7 byte read");
    bus_rd(10'h14, 32'h3C, "R7 status after drain");
    bus_rd(10'h24, 32'h3, "R7 level zero");
    bus_rd(10'h18, 32'h5A, "R7 empty read");
    bus_rd(10'h14, 32'h3C, "R7 empty read no effect");
    rx_send(8'h77);
    bus_wr(10'h10, 32'h0);
    bus_rd(10'h18, 32'h77, "R7 read while disabled");
    bus_rd(10'h14, 32'h0E, "R7 disabled no side effect");
    bus_rd(10'h24, 32'h0001_0003, "R7 disabled level held");
    bus_wr(10'h10, 32'h2);
    bus_rd(10'h18, 32'h77, "R7 drain");
    bus_rd(10'h14, 32'h3C, "R7 drained status");

    // R8 read-only slots
    bus_wr(10'h14, 32'hFFFF_FFFF);
    bus_wr(10'h18, 32'h0000_00FF);
    bus_wr(10'h24, 32'hFFFF_FFFF);
    bus_rd(10'h14, 32'h3C, "R8 status write ignored");
    bus_rd(10'h18, 32'h77, "R8 rx data write ignored");
    bus_rd(10'h24, 32'h3, "R8 fifo status write ignored");

    // R9 unmapped
    bus_wr(10'h0C, 32'hFFFF_FFFF);
    bus_wr(10'h40, 32'hFFFF_FFFF);
    bus_wr(10'h0A, 32'hFFFF_FFFF);
    bus_wr(10'h12, 32'h0);
    bus_rd(10'h0C, 32'h0, "R9 hole reads zero");
    bus_rd(10'h40, 32'h0, "R9 high offset reads zero");
    bus_rd(10'h11, 32'h0, "R9 misaligned reads zero");
    bus_rd(10'h00, 32'h0, "R9 state untouched");
    bus_rd(10'h04, 32'h0, "R9 enable untouched");
    bus_rd(10'h10, 32'h2, "R9 control untouched");

    // R10 transmit push
    bus_wr(10'h1C, 32'h0000_01AB);
    chk("R10 push pulse", tx_push, 1);
    chk("R10 push data", tx_push_data, 32'hAB);
    @(negedge clk);
    chk("R10 push one cycle", tx_push, 0);

    // R11 transmit status mirror
    tx_fifo_full = 1'b1; tx_fifo_empty = 1'b0;
    @(negedge clk);
    bus_rd(10'h14, 32'h39, "R11 tx full mirror");
    tx_fifo_full = 1'b0; tx_fifo_empty = 1'b1;
    @(negedge clk);

    // R12 fifo control and back-to-back reads
    bus_wr(10'h20, 32'h7C);
    chk("R12 fifo_ctrl_value", fifo_ctrl_value, 32'h7C);
    bus_rd(10'h20, 32'h7C, "R12 back-to-back first");
    bus_rd(10'h10, 32'h2, "R12 back-to-back second");
    bus_rd(10'h14, 32'h3C, "R12 back-to-back third");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R12 reads left unanswered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule